// File: doc/BRIEF.md
# Fetch-execute phase sequencer

This block is the control unit of a small accumulator processor. It produces the timing for each instruction as four consecutive clock cycles. A state bit that toggles every two cycles splits the instruction into a fetch half and an execute half. A pulse bit that toggles every cycle marks the second cycle of each half as its write strobe. So every instruction has four separate event times: fetch, fetch-write, execute and execute-write.

From the current phase, the 3-bit opcode held in the instruction register and a flag that reports whether the accumulator is zero, the block decodes fifteen one-bit datapath control lines. These are the ALU operation selects, a one-hot accumulator input select, a one-hot memory address select, the write enables, the program counter step and load controls, and a halt indication.

Sequencing starts on a run request and stops on a halt request or on a halt instruction. The datapath registers, the memory and the ALU sit outside this block.

Top module: `phase_seq`

## Requirements
- R1: After reset, and at any time the sequencer is idle, every phase output and every control output is 0. A run request seen at a clock edge while idle makes the next cycle a fetch cycle.
- R2: While running, the sequencer repeats a fixed four-cycle pattern:
  - first cycle: fetch only;
  - second cycle: fetch and fetch_wr;
  - third cycle: exec only;
  - fourth cycle: exec and exec_wr.
- R3: A halt request seen at a clock edge makes the sequencer idle from the next cycle, in any phase. A halt request takes priority over a simultaneous run request. A run request while running has no effect on the sequence.
- R4: In both fetch cycles, addr_pc is 1 and every other control line is 0, whatever the opcode. ir_we is 1 only in the fetch_wr cycle.
- R5: In both execute cycles of every opcode, exactly one of pc_inc and pc_ld is 1. pc_ld is chosen when the opcode is branch-if-zero (7) and r_zero is 1. pc_we is 1 only in the exec_wr cycle.
- R6: During execute, the opcodes add (1), and (2) and xor (3) each raise their own ALU select (alu_add, alu_and, alu_xor respectively), together with rsel_alu and addr_ir. r_we is 1 in exec_wr.
- R7: During execute, the remaining opcodes drive these lines:
  - load-immediate (4): rsel_ir, with r_we in exec_wr;
  - load (5): rsel_mem and addr_ir, with r_we in exec_wr;
  - store (6): addr_ir, with mem_we in exec_wr;
  - branch (7): raises none of the accumulator or memory lines.
- R8: The halt opcode (0) raises halt in both execute cycles. After its exec_wr cycle the sequencer is idle.
- R9: At most one of rsel_alu, rsel_mem and rsel_ir is 1 in any cycle. At most one of addr_pc and addr_ir is 1 in any cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| run | input | 1 | Start request |
| halt_req | input | 1 | Stop request |
| opcode | input | 3 | Opcode from the instruction register |
| r_zero | input | 1 | Accumulator equals zero |
| fetch | output | 1 | Fetch phase |
| fetch_wr | output | 1 | Fetch write strobe |
| exec | output | 1 | Execute phase |
| exec_wr | output | 1 | Execute write strobe |
| alu_add | output | 1 | ALU add select |
| alu_and | output | 1 | ALU and select |
| alu_xor | output | 1 | ALU xor select |
| rsel_alu | output | 1 | Accumulator input from ALU |
| rsel_mem | output | 1 | Accumulator input from memory |
| rsel_ir | output | 1 | Accumulator input from IR address field |
| addr_pc | output | 1 | Memory address from PC |
| addr_ir | output | 1 | Memory address from IR |
| ir_we | output | 1 | IR write enable |
| r_we | output | 1 | Accumulator write enable |
| pc_we | output | 1 | PC write enable |
| mem_we | output | 1 | Memory write enable |
| pc_inc | output | 1 | PC step by one |
| pc_ld | output | 1 | PC load from IR |
| halt | output | 1 | Halt instruction executing |

## Verification
A wrong running flag or a wrong phase counter shows up at the phase outputs in the very next cycle. It appears as a missing or doubled strobe, a fetch where an execute belongs, or activity while idle. Each cycle is compared against a behavioural model, so a slip in the pattern is seen in the cycle it happens.

A decode error appears in the execute cycle of the affected opcode, so each opcode is run with both values of r_zero. Garbage opcodes are applied during fetch to expose any leakage of the decode into fetch.

// File: rtl/phase_seq.sv
module phase_seq (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       run,
  input  logic       halt_req,
  input  logic [2:0] opcode,
  input  logic       r_zero,
  output logic       fetch,
  output logic       fetch_wr,
  output logic       exec,
  output logic       exec_wr,
  output logic       alu_add,
  output logic       alu_and,
  output logic       alu_xor,
  output logic       rsel_alu,
  output logic       rsel_mem,
  output logic       rsel_ir,
  output logic       addr_pc,
  output logic       addr_ir,
  output logic       ir_we,
  output logic       r_we,
  output logic       pc_we,
  output logic       mem_we,
  output logic       pc_inc,
  output logic       pc_ld,
  output logic       halt
);
  localparam logic [2:0] OP_HALT = 3'd0;
  localparam logic [2:0] OP_ADD  = 3'd1;
  localparam logic [2:0] OP_AND  = 3'd2;
  localparam logic [2:0] OP_XOR  = 3'd3;
  localparam logic [2:0] OP_LDI  = 3'd4;
  localparam logic [2:0] OP_LD   = 3'd5;
  localparam logic [2:0] OP_ST   = 3'd6;
  localparam logic [2:0] OP_BZ   = 3'd7;

  logic running, phase, pulse;

  always_ff @(posedge clk) begin
    if (!rst_n || halt_req) begin
      running <= 1'b0;
      phase   <= 1'b0;
      pulse   <= 1'b0;
    end else if (!running) begin
      running <= run;
      phase   <= 1'b0;
      pulse   <= 1'b0;
    end else if (phase && pulse && opcode == OP_HALT) begin
      running <= 1'b0;
      phase   <= 1'b0;
      pulse   <= 1'b0;
    end else begin
      pulse <= ~pulse;
      if (pulse) phase <= ~phase;
    end
  end

  assign fetch    = running & ~phase;
  assign exec     = running & phase;
  assign fetch_wr = fetch & pulse;
  assign exec_wr  = exec & pulse;

  logic is_alu, take_br;
  assign is_alu  = opcode == OP_ADD || opcode == OP_AND || opcode == OP_XOR;
  assign take_br = opcode == OP_BZ && r_zero;

  assign alu_add  = exec & (opcode == OP_ADD);
  assign alu_and  = exec & (opcode == OP_AND);
  assign alu_xor  = exec & (opcode == OP_XOR);
  assign rsel_alu = exec & is_alu;
  assign rsel_mem = exec & (opcode == OP_LD);
  assign rsel_ir  = exec & (opcode == OP_LDI);
  assign addr_pc  = fetch;
  assign addr_ir  = exec & (is_alu || opcode == OP_LD || opcode == OP_ST);
  assign ir_we    = fetch_wr;
  assign r_we     = exec_wr & (is_alu || opcode == OP_LD || opcode == OP_LDI);
  assign mem_we   = exec_wr & (opcode == OP_ST);
  assign pc_we    = exec_wr;
  assign pc_inc   = exec & ~take_br;
  assign pc_ld    = exec & take_br;
  assign halt     = exec & (opcode == OP_HALT);
endmodule

module phase_seq_chk (
  input logic clk, rst_n, halt_req,
  input logic fetch, fetch_wr, exec, exec_wr,
  input logic rsel_alu, rsel_mem, rsel_ir, addr_pc, addr_ir,
  input logic ir_we, mem_we, pc_inc, pc_ld, halt
);
  assert_rsel_onehot_R9: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({rsel_alu, rsel_mem, rsel_ir}));
  assert_addr_onehot_R9: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({addr_pc, addr_ir}));
  assert_fetch_to_exec_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (fetch_wr && !halt_req) |=> (exec && !exec_wr && !fetch));
  assert_exec_to_strobe_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (exec && !exec_wr && !halt_req) |=> exec_wr);
  assert_halt_req_stops_R3: assert property (@(posedge clk) disable iff (!rst_n)
    halt_req |=> (!fetch && !exec));
  assert_pc_exclusive_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !(pc_inc && pc_ld));
  assert_halt_stops_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (halt && exec_wr) |=> (!fetch && !exec));
  assert_store_addr_R7: assert property (@(posedge clk) disable iff (!rst_n)
    mem_we |-> addr_ir);
  assert_ir_addr_R4: assert property (@(posedge clk) disable iff (!rst_n)
    ir_we |-> addr_pc);
endmodule

bind phase_seq phase_seq_chk u_chk (.*);

// File: tb/test_phase_seq.sv
module test_phase_seq;
  logic clk = 0, rst_n = 0, run = 0, halt_req = 0, r_zero = 0;
  logic [2:0] opcode = 0;
  logic fetch, fetch_wr, exec, exec_wr, alu_add, alu_and, alu_xor;
  logic rsel_alu, rsel_mem, rsel_ir, addr_pc, addr_ir, ir_we, r_we, pc_we, mem_we;
  logic pc_inc, pc_ld, halt;
  integer errors = 0, checks = 0;
  integer m_run = 0, m_cnt = 0;
  logic done = 0;

  always #2 clk = ~clk;

  phase_seq i_phase_seq (.*);

  task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
    checks = checks + 1;
    if (act !== exp) begin
      errors = errors + 1;
      $display("FAIL %s act=%b exp=%b t=%0t", tag, act, exp, $time);
    end
  endtask

  task automatic compare;
    logic f, fw, e, ew;
    logic ea, en, ex, rsa, rsm, rsi, ap, ai, iw, rw, pw, mw, pi, pl, h;
    f  = m_run != 0 && m_cnt < 2;
    fw = m_run != 0 && m_cnt == 1;
    e  = m_run != 0 && m_cnt >= 2;
    ew = m_run != 0 && m_cnt == 3;
    ea = e && opcode == 1;
    en = e && opcode == 2;
    ex = e && opcode == 3;
    rsa = ea || en || ex;
    rsm = e && opcode == 5;
    rsi = e && opcode == 4;
    ap = f;
    ai = rsa || rsm || (e && opcode == 6);
    iw = fw;
    rw = ew && (opcode >= 1 && opcode <= 5);
    mw = ew && opcode == 6;
    pw = ew;
    pl = e && opcode == 7 && r_zero;
    pi = e && !pl;
    h  = e && opcode == 0;
    if (m_run == 0)
      chk("R1 idle", {1'b0, fetch | fetch_wr | exec | exec_wr | alu_add | alu_and | alu_xor,
          rsel_alu | rsel_mem | rsel_ir | addr_pc | addr_ir | ir_we | r_we,
          pc_we | mem_we | pc_inc | pc_ld | halt, 4'b0}, 8'd0);
    chk("R2/R3 phases", {4'b0, fetch, fetch_wr, exec, exec_wr}, {4'b0, f, fw, e, ew});
    chk("R4 fetch", {6'b0, addr_pc, ir_we}, {6'b0, ap, iw});
    chk("R5 pc", {5'b0, pc_inc, pc_ld, pc_we}, {5'b0, pi, pl, pw});
    chk("R6 alu", {4'b0, alu_add, alu_and, alu_xor, rsel_alu}, {4'b0, ea, en, ex, rsa});
    chk("R7 mem/ld", {3'b0, rsel_mem, rsel_ir, addr_ir, r_we, mem_we}, {3'b0, rsm, rsi, ai, rw, mw});
    chk("R8 halt", {7'b0, halt}, {7'b0, h});
    chk("R9 onehot", {6'b0, $countones({rsel_alu, rsel_mem, rsel_ir}) <= 1,
        $countones({addr_pc, addr_ir}) <= 1}, 8'b11);
  endtask

  task automatic cyc(input logic rn, input logic hr, input logic [2:0] op, input logic rz);
    run = rn; halt_req = hr; opcode = op; r_zero = rz;
    #1;
    if (rst_n) compare;
    @(posedge clk);
    if (!rst_n || hr) begin m_run = 0; m_cnt = 0; end
    else if (m_run == 0) begin m_run = rn ? 1 : 0; m_cnt = 0; end
    else if (m_cnt == 3 && op == 0) begin m_run = 0; m_cnt = 0; end
    else m_cnt = (m_cnt + 1) % 4;
    @(negedge clk);
  endtask

  task automatic instr(input logic [2:0] op, input logic rz, input logic [2:0] junk);
    cyc(0, 0, junk, ~rz);
    cyc(1, 0, junk + 3'd1, rz);
    cyc(0, 0, op, rz);
    cyc(0, 0, op, rz);
  endtask

  initial begin
    @(negedge clk);
    cyc(0, 0, 0, 0);
    cyc(1, 0, 0, 0);
    rst_n = 1;
    cyc(0, 0, 3, 1);
    chk("R1 reset", {4'b0, fetch, fetch_wr, exec, exec_wr}, 8'd0);
    cyc(0, 0, 5, 0);
    cyc(1, 0, 7, 1);
    for (int rz = 0; rz < 2; rz++)
      for (int op = 1; op < 8; op++)
        instr(op[2:0], rz[0], op[2:0] ^ 3'd5);
    instr(3'd0, 1'b0, 3'd2);
    cyc(0, 0, 1, 0);
    cyc(0, 0, 6, 1);
    cyc(1, 1, 0, 0);
    cyc(0, 0, 2, 0);
    cyc(1, 0, 0, 0);
    for (int k = 0; k < 11; k++) begin
      cyc(0, 0, 1, 0);
      cyc(0, k == 6, 5, 1);
    end
    cyc(1, 0, 4, 0);
    instr(3'd7, 1'b1, 3'd0);
    cyc(0, 0, 7, 0);
    cyc(0, 1, 7, 0);
    cyc(0, 0, 7, 0);
    done = 1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (100000) @(posedge clk);
        errors = errors + 1;
        checks = checks + 1;
        $display("FAIL watchdog act=timeout exp=done");
      end
    join_any
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule